// File: doc/BRIEF.md
# Configuration Access Address Router

This block sits between a configuration-space requester and a set of function register blocks. Each request carries a 24-bit address that the block splits into three fields: a bus number in bits [23:16], a device/function number (devfn) in bits [15:8], and a register offset in bits [7:0]. Within devfn, bits [7:3] name the device and bits [2:0] name the function. The block looks the bus number up in a small table of registered buses. Each table entry holds a bus number, an enable bit, and a 256-bit map of the devfn slots that are populated.

When the bus is found and the slot is populated, the access is forwarded one cycle later on a downstream port. The forwarded access carries the index of the matching table entry and the unchanged offset, length and write data. Read data that comes back from the selected function is relayed to the requester one cycle after it arrives.

When the bus is not found, or the slot is empty, the access ends inside the block. A read returns all-ones sized to the access: 0xFF for one byte, 0xFFFF for two bytes and 0xFFFFFFFF for any other length. A write is dropped without any response. Table entries are loaded through a separate port. The reset input is asynchronous, active low, and its release is synchronised inside the block.

Top module: `cfg_access_router`

## Requirements
- R1: A forwarded access presents the request's devfn (address bits [15:8]), its device number (devfn bits [7:3]), its function number (devfn bits [2:0]), its offset (address bits [7:0]), its length, its write flag and its write data, all unchanged.
- R2: When several enabled table entries hold the requested bus number, the entry with the lowest index is used, for both the forwarding index and the slot-map check.
- R3: A request to a populated slot on a registered bus raises `fwd_valid` for exactly one cycle, on the clock edge after the one that accepted the request.
- R4: A read to a bus number held by no enabled entry raises `rsp_valid` one cycle after the request. Its data is 0x000000FF for length 1, 0x0000FFFF for length 2 and 0xFFFFFFFF for any other length. Nothing is forwarded.
- R5: A read to a registered bus whose slot-map bit for the requested devfn is clear completes the same way as R4, with no forwarding.
- R6: A write to an unregistered bus or an empty slot produces neither `fwd_valid` nor `rsp_valid`.
- R7: A target read response (`tgt_rvalid` with `tgt_rdata`) appears on `rsp_valid` and `rsp_rdata` one cycle later, with the data unchanged.
- R8: A table entry whose enable bit is clear never matches, even when its bus number equals the requested bus.
- R9: A table write that is accepted on one clock edge governs every request accepted on a later edge.
- R10: After reset, every table entry is disabled and `fwd_valid` and `rsp_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 24 | Bus [23:16], devfn [15:8], offset [7:0] |
| req_len | input | 3 | Access length in bytes |
| req_wdata | input | 32 | Write data |
| tbl_we | input | 1 | Table entry write strobe |
| tbl_idx | input | 2 | Table entry index |
| tbl_bus | input | 8 | Bus number stored in the entry |
| tbl_en | input | 1 | Entry enable bit |
| tbl_map | input | 256 | Populated-slot map, one bit per devfn |
| fwd_valid | output | 1 | Forwarded access strobe |
| fwd_write | output | 1 | Forwarded write flag |
| fwd_port | output | 2 | Index of the matching table entry |
| fwd_devfn | output | 8 | Forwarded devfn |
| fwd_dev | output | 5 | Device number |
| fwd_func | output | 3 | Function number |
| fwd_offset | output | 8 | Register offset |
| fwd_len | output | 3 | Access length |
| fwd_wdata | output | 32 | Write data |
| tgt_rvalid | input | 1 | Target read data strobe |
| tgt_rdata | input | 32 | Target read data |
| rsp_valid | output | 1 | Read response strobe |
| rsp_rdata | output | 32 | Read response data |

## Verification
Some behaviours are checked by assertions on every cycle:
- every forwarded access follows a request by one cycle and keeps its offset;
- a request with no hit never forwards;
- a dropped write never produces a response;
- a target response is relayed after one cycle with its data intact;
- at most one table entry is selected.

Other behaviours can only be shown by the bench's scenarios:
- that the lowest matching entry wins when a populated slot in a later entry is hidden by it;
- that a disabled entry with a matching bus number is skipped;
- that the all-ones value tracks the access length;
- that a table rewrite takes effect on the next request;
- that reset clears the table.

// File: rtl/cfg_route_pkg.sv
package cfg_route_pkg;
  localparam int BUS_W   = 8;
  localparam int DEVFN_W = 8;
  localparam int OFF_W   = 8;
  localparam int ADDR_W  = BUS_W + DEVFN_W + OFF_W;
  localparam int SLOTS   = 2 ** DEVFN_W;
  localparam int FUNC_W  = 3;
  localparam int DEV_W   = DEVFN_W - FUNC_W;
  localparam int LEN_W   = 3;
  localparam int DATA_W  = 32;

  typedef struct packed {
    logic [BUS_W-1:0]   bus;
    logic [DEVFN_W-1:0] devfn;
    logic [OFF_W-1:0]   offset;
  } cfg_addr_t;

  // All-ones value sized to the access length (1 or 2 bytes, else full word).
  function automatic logic [DATA_W-1:0] ones_for_len(input logic [LEN_W-1:0] len);
    logic [DATA_W-1:0] v;
    case (len)
      3'd1:    v = 32'h0000_00FF;
      3'd2:    v = 32'h0000_FFFF;
      default: v = 32'hFFFF_FFFF;
    endcase
    return v;
  endfunction
endpackage

// File: rtl/cfg_bus_table.sv
module cfg_bus_table
  import cfg_route_pkg::*;
#(
  parameter int N_BUS = 4,
  localparam int IDX_W = (N_BUS > 1) ? $clog2(N_BUS) : 1
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_en,
  input  logic [IDX_W-1:0]                wr_idx,
  input  logic [BUS_W-1:0]                wr_bus,
  input  logic                            wr_vld,
  input  logic [SLOTS-1:0]                wr_map,
  output logic [N_BUS-1:0]                ent_vld,
  output logic [N_BUS-1:0][BUS_W-1:0]     ent_bus,
  output logic [N_BUS-1:0][SLOTS-1:0]     ent_map
);
  for (genvar i = 0; i < N_BUS; i++) begin : g_ent
    logic             sel;
    logic             vld_d, vld_q;
    logic [BUS_W-1:0] bus_q;
    logic [SLOTS-1:0] map_q;

    assign sel = wr_en && (wr_idx == IDX_W'(i));

    always_comb begin
      vld_d = vld_q;
      if (sel) vld_d = wr_vld;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) vld_q <= 1'b0;
      else        vld_q <= vld_d;
    end

    always_ff @(posedge clk) begin
      if (sel) begin
        bus_q <= wr_bus;
        map_q <= wr_map;
      end
    end

    assign ent_vld[i] = vld_q;
    assign ent_bus[i] = bus_q;
    assign ent_map[i] = map_q;

    // R10: entries come out of reset disabled
    a_r10_entry_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> !vld_q);
  end
endmodule

// File: rtl/cfg_bus_lookup.sv
module cfg_bus_lookup
  import cfg_route_pkg::*;
#(
  parameter int N_BUS = 4,
  localparam int IDX_W = (N_BUS > 1) ? $clog2(N_BUS) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [BUS_W-1:0]            q_bus,
  input  logic [DEVFN_W-1:0]          q_devfn,
  input  logic [N_BUS-1:0]            ent_vld,
  input  logic [N_BUS-1:0][BUS_W-1:0] ent_bus,
  input  logic [N_BUS-1:0][SLOTS-1:0] ent_map,
  output logic                        bus_found,
  output logic                        hit,
  output logic [IDX_W-1:0]            hit_idx
);
  logic [N_BUS-1:0] match;
  logic [N_BUS-1:0] first_oh;
  logic             present;

  for (genvar i = 0; i < N_BUS; i++) begin : g_cmp
    assign match[i] = ent_vld[i] && (ent_bus[i] == q_bus);
  end

  // Lowest index wins
  always_comb begin
    bus_found = 1'b0;
    hit_idx   = '0;
    first_oh  = '0;
    for (int i = 0; i < N_BUS; i++) begin
      if (match[i] && !bus_found) begin
        bus_found   = 1'b1;
        hit_idx     = IDX_W'(i);
        first_oh[i] = 1'b1;
      end
    end
  end

  assign present = ent_map[hit_idx][q_devfn];
  assign hit     = bus_found && present;

  // R2: a single entry is selected
  a_r2_single_select: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(first_oh));
  // R8: a disabled entry can never be the selected one
  a_r8_disabled_skipped: assert property (@(posedge clk) disable iff (!rst_n)
    bus_found |-> ent_vld[hit_idx]);
endmodule

// File: rtl/cfg_resp_path.sv
module cfg_resp_path
  import cfg_route_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              local_rd,
  input  logic [LEN_W-1:0]  local_len,
  input  logic              tgt_rvalid,
  input  logic [DATA_W-1:0] tgt_rdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);
  logic              vld_d, vld_q;
  logic              dat_en;
  logic [DATA_W-1:0] dat_d, dat_q;

  always_comb begin
    vld_d  = tgt_rvalid || local_rd;
    dat_en = vld_d;
    dat_d  = tgt_rvalid ? tgt_rdata : ones_for_len(local_len);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk) begin
    if (dat_en) dat_q <= dat_d;
  end

  assign rsp_valid = vld_q;
  assign rsp_rdata = dat_q;

  // R7: target data relayed one cycle later, untouched
  a_r7_relay: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_rvalid |=> (rsp_valid && rsp_rdata == $past(tgt_rdata)));
  // R4: a local completion returns ones sized to the length
  a_r4_local_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (local_rd && !tgt_rvalid) |=> (rsp_rdata == ones_for_len($past(local_len))));
endmodule

// File: rtl/cfg_access_router.sv
module cfg_access_router
  import cfg_route_pkg::*;
#(
  parameter int N_BUS = 4,
  localparam int IDX_W = (N_BUS > 1) ? $clog2(N_BUS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [LEN_W-1:0]   req_len,
  input  logic [DATA_W-1:0]  req_wdata,
  input  logic               tbl_we,
  input  logic [IDX_W-1:0]   tbl_idx,
  input  logic [BUS_W-1:0]   tbl_bus,
  input  logic               tbl_en,
  input  logic [SLOTS-1:0]   tbl_map,
  output logic               fwd_valid,
  output logic               fwd_write,
  output logic [IDX_W-1:0]   fwd_port,
  output logic [DEVFN_W-1:0] fwd_devfn,
  output logic [DEV_W-1:0]   fwd_dev,
  output logic [FUNC_W-1:0]  fwd_func,
  output logic [OFF_W-1:0]   fwd_offset,
  output logic [LEN_W-1:0]   fwd_len,
  output logic [DATA_W-1:0]  fwd_wdata,
  input  logic               tgt_rvalid,
  input  logic [DATA_W-1:0]  tgt_rdata,
  output logic               rsp_valid,
  output logic [DATA_W-1:0]  rsp_rdata
);
  // Reset: asserted asynchronously, released on the clock
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  cfg_addr_t a;
  assign a = cfg_addr_t'(req_addr);

  logic [N_BUS-1:0]            ent_vld;
  logic [N_BUS-1:0][BUS_W-1:0] ent_bus;
  logic [N_BUS-1:0][SLOTS-1:0] ent_map;
  logic                        bus_found, lk_hit;
  logic [IDX_W-1:0]            lk_idx;

  cfg_bus_table #(.N_BUS(N_BUS)) u_table (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (tbl_we),
    .wr_idx  (tbl_idx),
    .wr_bus  (tbl_bus),
    .wr_vld  (tbl_en),
    .wr_map  (tbl_map),
    .ent_vld (ent_vld),
    .ent_bus (ent_bus),
    .ent_map (ent_map)
  );

  cfg_bus_lookup #(.N_BUS(N_BUS)) u_lookup (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .q_bus     (a.bus),
    .q_devfn   (a.devfn),
    .ent_vld   (ent_vld),
    .ent_bus   (ent_bus),
    .ent_map   (ent_map),
    .bus_found (bus_found),
    .hit       (lk_hit),
    .hit_idx   (lk_idx)
  );

  // Forward stage
  logic               fv_d, fv_q;
  logic               f_en;
  logic               fw_q;
  logic [IDX_W-1:0]   fp_q;
  logic [DEVFN_W-1:0] fd_q;
  logic [OFF_W-1:0]   fo_q;
  logic [LEN_W-1:0]   fl_q;
  logic [DATA_W-1:0]  fdat_q;
  logic               local_rd;

  always_comb begin
    fv_d     = req_valid && lk_hit;
    f_en     = fv_d;
    local_rd = req_valid && !lk_hit && !req_write;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) fv_q <= 1'b0;
    else             fv_q <= fv_d;
  end

  always_ff @(posedge clk) begin
    if (f_en) begin
      fw_q   <= req_write;
      fp_q   <= lk_idx;
      fd_q   <= a.devfn;
      fo_q   <= a.offset;
      fl_q   <= req_len;
      fdat_q <= req_wdata;
    end
  end

  assign fwd_valid  = fv_q;
  assign fwd_write  = fw_q;
  assign fwd_port   = fp_q;
  assign fwd_devfn  = fd_q;
  assign fwd_dev    = fd_q[DEVFN_W-1:FUNC_W];
  assign fwd_func   = fd_q[FUNC_W-1:0];
  assign fwd_offset = fo_q;
  assign fwd_len    = fl_q;
  assign fwd_wdata  = fdat_q;

  cfg_resp_path u_resp (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .local_rd   (local_rd),
    .local_len  (req_len),
    .tgt_rvalid (tgt_rvalid),
    .tgt_rdata  (tgt_rdata),
    .rsp_valid  (rsp_valid),
    .rsp_rdata  (rsp_rdata)
  );

  // R3: forwarding only follows an accepted request
  a_r3_fwd_after_req: assert property (@(posedge clk) disable iff (!rst_sync_n)
    fwd_valid |-> $past(req_valid));
  // R1: the offset travels unchanged
  a_r1_offset_kept: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_valid && lk_hit) |=> (fwd_offset == $past(req_addr[OFF_W-1:0])));
  // R4/R5: no forwarding without a hit
  a_r4_miss_no_fwd: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_valid && !lk_hit) |=> !fwd_valid);
  // R6: a dropped write raises no response
  a_r6_drop_write: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_valid && req_write && !lk_hit && !tgt_rvalid) |=> !rsp_valid);
endmodule

// File: tb/cfg_access_router_tb_top.sv
`timescale 1ns/1ps
module cfg_access_router_tb_top;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic         rst_n;
  logic         req_valid, req_write;
  logic [23:0]  req_addr;
  logic [2:0]   req_len;
  logic [31:0]  req_wdata;
  logic         tbl_we, tbl_en;
  logic [1:0]   tbl_idx;
  logic [7:0]   tbl_bus;
  logic [255:0] tbl_map;
  logic         fwd_valid, fwd_write;
  logic [1:0]   fwd_port;
  logic [7:0]   fwd_devfn, fwd_offset;
  logic [4:0]   fwd_dev;
  logic [2:0]   fwd_func, fwd_len;
  logic [31:0]  fwd_wdata;
  logic         tgt_rvalid;
  logic [31:0]  tgt_rdata;
  logic         rsp_valid;
  logic [31:0]  rsp_rdata;

  cfg_access_router dut_i (.*);

  // Target model: answers a forwarded read one cycle later with a tagged word
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_rvalid <= 1'b0;
      tgt_rdata  <= '0;
    end else begin
      tgt_rvalid <= fwd_valid && !fwd_write;
      tgt_rdata  <= {8'hA5, fwd_devfn, fwd_offset, 5'd0, fwd_len};
    end
  end

  int total = 0, bad = 0;
  bit done = 0;

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic load(input int idx, input logic [7:0] bus, input logic en,
                      input logic [255:0] map);
    @(negedge clk);
    tbl_we = 1; tbl_idx = 2'(idx); tbl_bus = bus; tbl_en = en; tbl_map = map;
    @(negedge clk);
    tbl_we = 0;
  endtask

  // Issue one request; observe forwarding and any response over four cycles
  task automatic run(input logic wr, input logic [23:0] ad, input logic [2:0] ln,
                     input logic [31:0] wd, output logic fv, output logic [1:0] fp,
                     output int nrsp, output logic [31:0] rd);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = ad; req_len = ln; req_wdata = wd;
    @(negedge clk);
    req_valid = 0;
    fv = fwd_valid; fp = fwd_port; nrsp = 0; rd = '0;
    if (fwd_valid) begin
      chk("R1 devfn", {24'd0, fwd_devfn}, {24'd0, ad[15:8]});
      chk("R1 dev/func", {24'd0, fwd_dev, fwd_func}, {24'd0, ad[15:8]});
      chk("R1 offset", {24'd0, fwd_offset}, {24'd0, ad[7:0]});
      chk("R1 len/write", {28'd0, fwd_len, fwd_write}, {28'd0, ln, wr});
      if (wr) chk("R1 wdata", fwd_wdata, wd);
    end
    for (int c = 0; c < 4; c++) begin
      if (c > 0) @(negedge clk);
      if (c > 0 && fwd_valid) chk("R3 single-cycle fwd", 32'd1, 32'd0);
      if (rsp_valid) begin nrsp++; rd = rsp_rdata; end
    end
  endtask

  typedef struct packed {
    logic        wr;
    logic [23:0] addr;
    logic [2:0]  len;
    logic        fwd;
    logic [1:0]  port;
    logic        rsp;
    logic [31:0] data;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 24'h000004, 3'd4, 1'b1, 2'd0, 1'b1, 32'hA5000404, 8'd3},
    '{1'b0, 24'h000810, 3'd2, 1'b1, 2'd0, 1'b1, 32'hA5081002, 8'd7},
    '{1'b0, 24'h001100, 3'd1, 1'b1, 2'd0, 1'b1, 32'hA5110001, 8'd1},
    '{1'b0, 24'h000900, 3'd4, 1'b0, 2'd0, 1'b1, 32'hFFFFFFFF, 8'd5},
    '{1'b0, 24'h000901, 3'd2, 1'b0, 2'd0, 1'b1, 32'h0000FFFF, 8'd5},
    '{1'b0, 24'h000902, 3'd1, 1'b0, 2'd0, 1'b1, 32'h000000FF, 8'd5},
    '{1'b0, 24'h030000, 3'd4, 1'b0, 2'd0, 1'b1, 32'hFFFFFFFF, 8'd4},
    '{1'b0, 24'h030000, 3'd1, 1'b0, 2'd0, 1'b1, 32'h000000FF, 8'd4},
    '{1'b0, 24'h030000, 3'd2, 1'b0, 2'd0, 1'b1, 32'h0000FFFF, 8'd4},
    '{1'b0, 24'h052000, 3'd4, 1'b1, 2'd1, 1'b1, 32'hA5200004, 8'd2},
    '{1'b0, 24'h052100, 3'd4, 1'b0, 2'd0, 1'b1, 32'hFFFFFFFF, 8'd2},
    '{1'b0, 24'h070000, 3'd2, 1'b0, 2'd0, 1'b1, 32'h0000FFFF, 8'd8},
    '{1'b1, 24'h000004, 3'd4, 1'b1, 2'd0, 1'b0, 32'h0,        8'd3},
    '{1'b1, 24'h030000, 3'd4, 1'b0, 2'd0, 1'b0, 32'h0,        8'd6},
    '{1'b1, 24'h000900, 3'd2, 1'b0, 2'd0, 1'b0, 32'h0,        8'd6},
    '{1'b0, 24'h000903, 3'd3, 1'b0, 2'd0, 1'b1, 32'hFFFFFFFF, 8'd4}
  };

  initial begin
    logic fv; logic [1:0] fp; int nr; logic [31:0] rd;
    logic [255:0] m;
    rst_n = 0; req_valid = 0; req_write = 0; req_addr = '0; req_len = '0;
    req_wdata = '0; tbl_we = 0; tbl_idx = '0; tbl_bus = '0; tbl_en = 0; tbl_map = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk("R10 fwd_valid after reset", {31'd0, fwd_valid}, 32'd0);
    chk("R10 rsp_valid after reset", {31'd0, rsp_valid}, 32'd0);

    // Table: entry0 bus 0 slots 00/08/11; entry1 bus 5 slot 20;
    // entry2 bus 5 slot 21 (hidden by entry1); entry3 bus 7 disabled with slot 00
    m = '0; m[8'h00] = 1; m[8'h08] = 1; m[8'h11] = 1; load(0, 8'h00, 1, m);
    m = '0; m[8'h20] = 1; load(1, 8'h05, 1, m);
    m = '0; m[8'h21] = 1; load(2, 8'h05, 1, m);
    m = '0; m[8'h00] = 1; load(3, 8'h07, 0, m);

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d vec%0d", VECS[i].req, i);
      run(VECS[i].wr, VECS[i].addr, VECS[i].len, 32'hC0DE_0000 + i, fv, fp, nr, rd);
      chk({tag, " fwd"}, {31'd0, fv}, {31'd0, VECS[i].fwd});
      if (VECS[i].fwd) chk({tag, " port"}, {30'd0, fp}, {30'd0, VECS[i].port});
      chk({tag, " rsp count"}, nr, VECS[i].rsp ? 32'd1 : 32'd0);
      if (VECS[i].rsp) chk({tag, " rdata"}, rd, VECS[i].data);
    end

    // R9: enable entry3 and the next request to bus 7 is forwarded on port 3
    m = '0; m[8'h00] = 1; load(3, 8'h07, 1, m);
    run(0, 24'h070000, 3'd4, 0, fv, fp, nr, rd);
    chk("R9 fwd after table write", {31'd0, fv}, 32'd1);
    chk("R9 port", {30'd0, fp}, 32'd3);
    chk("R9 rdata", rd, 32'hA5000004);

    // R8: disabling entry0 turns a former hit into an all-ones read
    load(0, 8'h00, 0, 256'd1);
    run(0, 24'h000004, 3'd2, 0, fv, fp, nr, rd);
    chk("R8 disabled entry no fwd", {31'd0, fv}, 32'd0);
    chk("R8 disabled entry rdata", rd, 32'h0000FFFF);

    // R10: reset in mid-run clears the table
    @(negedge clk); rst_n = 0;
    repeat (2) @(negedge clk); rst_n = 1;
    repeat (4) @(negedge clk);
    run(0, 24'h052000, 3'd4, 0, fv, fp, nr, rd);
    chk("R10 table cleared no fwd", {31'd0, fv}, 32'd0);
    chk("R10 table cleared rdata", rd, 32'hFFFFFFFF);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule